// File: doc/BRIEF.md
# Pipelined Banded Row Dot-Product Reducer

This unit forms one dot product per clock for a row-by-row matrix-vector product over a banded matrix. Each cycle it can accept one row of `2*HALF_BW-1` signed fixed-point coefficients, read in parallel from separate per-column memories, together with the matching window of vector elements. All lane products are formed at once. A registered binary adder tree then sums them, so an N-row product enters in N consecutive cycles.

The pipeline is deeper than one cycle. Each row therefore carries a valid bit and a small context tag, and both travel beside its data. A solver can interleave rows from several independent problems and keep the unit busy on every cycle. The tag identifies which problem each result belongs to. Results come out in the order the rows went in. The final sum saturates to the output width.

Top module: `band_dot_reducer`

## Requirements
- R1: While reset is asserted, and until the first accepted row has passed through the pipeline, `out_valid` is low.
- R2: For an accepted row, `out_sum` equals the exact signed sum over all lanes i of coefficient lane i times vector lane i, when that sum lies inside the output range. Lane i occupies bits `[i*W +: W]` of its flat bus, and lane 0 is in the least significant bits.
- R3: A row accepted at a clock edge gives its result with `out_valid` high exactly `1 + ceil(log2(2*HALF_BW-1))` edges later.
- R4: A new row can be accepted on every cycle. Back-to-back rows give results on consecutive cycles.
- R5: The `out_tag` delivered with a result equals the `in_tag` of the row that produced it.
- R6: Results leave in the same order as their rows were accepted.
- R7: A row sum above `2^(OUT_W-1)-1` is delivered as `2^(OUT_W-1)-1`.
- R8: A row sum below `-2^(OUT_W-1)` is delivered as `-2^(OUT_W-1)`.
- R9: A cycle with `in_valid` low produces no result: `out_valid` is low at the matching output cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the control pipeline |
| in_valid | input | 1 | Row present on the inputs this cycle |
| in_tag | input | TAG_W | Problem context tag of the row |
| in_coef | input | (2*HALF_BW-1)*COEF_W | Flat signed coefficient lanes, lane 0 in the low bits |
| in_vec | input | (2*HALF_BW-1)*VEC_W | Flat signed vector window lanes, aligned to the coefficients |
| out_valid | output | 1 | Result present this cycle |
| out_tag | output | TAG_W | Tag that travelled with the row |
| out_sum | output | OUT_W | Saturated signed dot product |

## Verification
With the default seven lanes, every result is due four edges after its row is captured: one product register plus three tree levels. The bench drives each row on a falling edge and records the expected valid, tag and saturated sum under the step index. On every later falling edge it compares the outputs against the entry from four steps earlier. Idle steps are recorded as well, so bubbles, back-to-back bursts and tag order are all checked against the same fixed offset.

// File: rtl/band_dot_reducer.sv
module band_dot_reducer #(
  parameter int HALF_BW = 4,
  parameter int COEF_W  = 16,
  parameter int VEC_W   = 16,
  parameter int OUT_W   = 24,
  parameter int TAG_W   = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [TAG_W-1:0]            in_tag,
  input  logic [(2*HALF_BW-1)*COEF_W-1:0] in_coef,
  input  logic [(2*HALF_BW-1)*VEC_W-1:0]  in_vec,
  output logic                        out_valid,
  output logic [TAG_W-1:0]            out_tag,
  output logic [OUT_W-1:0]            out_sum
);
  localparam int LANES  = 2*HALF_BW - 1;
  localparam int DEPTH  = $clog2(LANES);
  localparam int PAD    = 1 << DEPTH;
  localparam int PROD_W = COEF_W + VEC_W;
  localparam int SUM_W  = PROD_W + DEPTH;
  localparam int LAT    = 1 + DEPTH;
  localparam int CW     = $clog2(LAT + 2) + 1;

  genvar l, i;
  for (l = 0; l <= DEPTH; l++) begin : lv
    localparam int W = PAD >> l;
    logic signed [SUM_W-1:0] s [W];
    if (l == 0) begin : leaf
      for (i = 0; i < W; i++) begin : ln
        if (i < LANES) begin : act
          logic signed [COEF_W-1:0] a;
          logic signed [VEC_W-1:0]  b;
          logic signed [PROD_W-1:0] p;
          assign a = in_coef[i*COEF_W +: COEF_W];
          assign b = in_vec[i*VEC_W +: VEC_W];
          assign p = a * b;
          always_ff @(posedge clk) s[i] <= SUM_W'(p);
        end else begin : pad
          always_ff @(posedge clk) s[i] <= '0;
        end
      end
    end else begin : node
      for (i = 0; i < W; i++) begin : nd
        always_ff @(posedge clk) s[i] <= lv[l-1].s[2*i] + lv[l-1].s[2*i+1];
      end
    end
  end

  logic [LAT-1:0]   vpipe;
  logic [TAG_W-1:0] tpipe [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vpipe <= '0;
      for (int j = 0; j < LAT; j++) tpipe[j] <= '0;
    end else begin
      vpipe    <= LAT'({vpipe, in_valid});
      tpipe[0] <= in_tag;
      for (int j = 1; j < LAT; j++) tpipe[j] <= tpipe[j-1];
    end
  end

  logic signed [SUM_W-1:0] fin;
  assign fin       = lv[DEPTH].s[0];
  assign out_valid = vpipe[LAT-1];
  assign out_tag   = tpipe[LAT-1];

  if (OUT_W >= SUM_W) begin : wide
    assign out_sum = OUT_W'(fin);
  end else begin : clamp
    localparam logic signed [SUM_W-1:0] HI = SUM_W'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
    localparam logic signed [SUM_W-1:0] LO = -HI - SUM_W'(1);
    assign out_sum = (fin > HI) ? HI[OUT_W-1:0] :
                     (fin < LO) ? LO[OUT_W-1:0] : fin[OUT_W-1:0];
  end

  logic [CW-1:0] inflight;
  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + CW'(in_valid) - CW'(out_valid);
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |=> !out_valid);
  assert_inflight_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CW'(LAT));
  assert_no_orphan_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> inflight != '0);
  assert_pos_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !fin[SUM_W-1]) |-> !out_sum[OUT_W-1]);
  assert_neg_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fin[SUM_W-1]) |-> out_sum[OUT_W-1]);
endmodule

// File: tb/band_dot_reducer_test.sv
`timescale 1ns/1ps
module band_dot_reducer_test;
  localparam int HALF_BW = 4;
  localparam int COEF_W  = 16;
  localparam int VEC_W   = 16;
  localparam int OUT_W   = 24;
  localparam int TAG_W   = 3;
  localparam int LANES   = 2*HALF_BW - 1;
  localparam int LAT     = 1 + $clog2(LANES);
  localparam int CBW     = LANES*COEF_W;
  localparam int VBW     = LANES*VEC_W;
  localparam int NSTEP   = 4000;
  localparam longint HI  = (64'sd1 <<< (OUT_W-1)) - 1;
  localparam longint LO  = -HI - 1;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [TAG_W-1:0] in_tag = '0;
  logic [CBW-1:0] in_coef = '0;
  logic [VBW-1:0] in_vec = '0;
  logic out_valid;
  logic [TAG_W-1:0] out_tag;
  logic [OUT_W-1:0] out_sum;

  band_dot_reducer #(.HALF_BW(HALF_BW), .COEF_W(COEF_W), .VEC_W(VEC_W),
    .OUT_W(OUT_W), .TAG_W(TAG_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
    .in_coef(in_coef), .in_vec(in_vec), .out_valid(out_valid),
    .out_tag(out_tag), .out_sum(out_sum));

  always #2 clk = ~clk;

  int tests = 0, fails = 0, k = 0;
  bit done = 0;
  bit h_val [NSTEP];
  logic [TAG_W-1:0] h_tag [NSTEP];
  longint h_sum [NSTEP];
  longint h_raw [NSTEP];
  logic [TAG_W-1:0] seq_tag = '0;

  function automatic longint raw_dot(input logic [CBW-1:0] c, input logic [VBW-1:0] v);
    longint acc = 0;
    for (int i = 0; i < LANES; i++)
      acc += longint'($signed(c[i*COEF_W +: COEF_W])) * longint'($signed(v[i*VEC_W +: VEC_W]));
    return acc;
  endfunction

  function automatic longint clampv(input longint x);
    return (x > HI) ? HI : (x < LO) ? LO : x;
  endfunction

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (step %0d)", req, act, exp, k);
    end
  endtask

  task automatic step(input bit v, input logic [CBW-1:0] c, input logic [VBW-1:0] x);
    @(negedge clk);
    if (k >= LAT) begin
      int j = k - LAT;
      if (h_val[j]) begin
        longint got = longint'($signed(out_sum));
        string r = (h_raw[j] > HI) ? "R7" : (h_raw[j] < LO) ? "R8" : "R2";
        check("R3", out_valid == 1'b1, longint'(out_valid), 1);
        check("R5/R6", out_tag == h_tag[j], longint'(out_tag), longint'(h_tag[j]));
        check(r, got == h_sum[j], got, h_sum[j]);
      end else begin
        check("R9", out_valid == 1'b0, longint'(out_valid), 0);
      end
    end else begin
      check("R1", out_valid == 1'b0, longint'(out_valid), 0);
    end
    in_valid = v;
    in_coef = c;
    in_vec = x;
    in_tag = seq_tag;
    h_val[k] = v;
    h_tag[k] = seq_tag;
    h_raw[k] = raw_dot(c, x);
    h_sum[k] = clampv(h_raw[k]);
    if (v) seq_tag = seq_tag + 1'b1;
    k++;
  endtask

  function automatic logic [CBW-1:0] rnd_c(input int mag);
    logic [CBW-1:0] r;
    for (int i = 0; i < LANES; i++)
      r[i*COEF_W +: COEF_W] = (mag == 0) ? COEF_W'($urandom) : COEF_W'(int'($urandom % (2*mag+1)) - mag);
    return r;
  endfunction

  function automatic logic [VBW-1:0] rnd_v(input int mag);
    logic [VBW-1:0] r;
    for (int i = 0; i < LANES; i++)
      r[i*VEC_W +: VEC_W] = (mag == 0) ? VEC_W'($urandom) : VEC_W'(int'($urandom % (2*mag+1)) - mag);
    return r;
  endfunction

  initial begin
    logic [CBW-1:0] cmax, c1;
    logic [VBW-1:0] vmax, vmin, v1;
    void'($urandom(32'd1234));
    repeat (3) begin
      @(negedge clk);
      check("R1", out_valid == 1'b0, longint'(out_valid), 0);
    end
    rst_n = 1;
    for (int i = 0; i < LANES; i++) begin
      cmax[i*COEF_W +: COEF_W] = {1'b0, {(COEF_W-1){1'b1}}};
      vmax[i*VEC_W +: VEC_W]   = {1'b0, {(VEC_W-1){1'b1}}};
      vmin[i*VEC_W +: VEC_W]   = {1'b1, {(VEC_W-1){1'b0}}};
    end
    // R2: single active lane, each lane in turn
    for (int i = 0; i < LANES; i++) begin
      c1 = '0; v1 = '0;
      c1[i*COEF_W +: COEF_W] = COEF_W'(i + 3);
      v1[i*VEC_W +: VEC_W]   = VEC_W'(-(i + 5));
      step(1'b1, c1, v1);
    end
    // R7, R8: saturation both ways, back to back (R4)
    step(1'b1, cmax, vmax);
    step(1'b1, cmax, vmin);
    step(1'b1, '0, '0);
    // R9: bubbles between rows
    step(1'b0, cmax, vmax);
    step(1'b1, rnd_c(500), rnd_v(500));
    step(1'b0, '0, '0);
    step(1'b0, '0, '0);
    step(1'b1, rnd_c(500), rnd_v(500));
    // Random mix: mostly in range, some full-scale
    for (int n = 0; n < 2000; n++) begin
      bit v = ($urandom % 10) < 8;
      int mag = (($urandom % 12) == 0) ? 0 : 800;
      step(v, rnd_c(mag), rnd_v(mag));
    end
    for (int n = 0; n <= LAT + 1; n++) step(1'b0, '0, '0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule